// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block sits beside the bus engine of an I2C controller. It collects seven kinds of event into a sticky status word: arbitration lost, no-acknowledge, access ready, receive data ready, transmit data ready, stop detected and addressed as slave. A per-source enable mask gates them. The block presents one small vector code for the enabled pending event with the highest priority. It also raises a single interrupt line whenever any enabled event is pending. A service routine reads the vector, handles the reported event, and reads again until the code is zero.

Two ways of clearing coexist. A read strobe on the vector clears the event it reported. A write to the status register clears every bit that is written as one. Two further status bits, receive shift full and bus busy, mirror live conditions from the bus engine. Neither kind of clear touches them, and they never raise the interrupt.

Top module: `i2c_irq_vec`

## Requirements
- R1: After reset the status word is zero, the vector is 0, the interrupt is low and every source is disabled in the mask.
- R2: A one-cycle strobe on event input k sets status bit k on the next clock edge, and the bit stays set until cleared. The positions are arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R3: The vector equals k+1 for the lowest k whose status bit and mask bit are both set, giving codes 1 to 7 in the order of R2. It is 0 when no enabled event is pending.
- R4: The interrupt is high exactly when the vector is nonzero, that is when any enabled event is pending.
- R5: A register write with select 0 loads the mask from the write data, using the bit positions of R2. A masked-out event stays in status but is neither reported nor interrupting.
- R6: A register write with select 1 clears each status bit 0 to 6 whose data bit is 1, and leaves the bits written 0 unchanged.
- R7: A vector read strobe clears only the status bit of the code currently reported. When the vector is 0 it changes nothing.
- R8: An event strobe in the same cycle as a write-one clear or a vector-read clear of the same bit leaves that bit set.
- R9: Status bit 11 follows the receive-shift-full input and bit 12 follows the bus-busy input, one clock later. Neither clear affects them, they never raise the interrupt, and status bits 7 to 10 and 13 to 15 read 0.
- R10: Clearing the transmit-ready enable drops the interrupt for a pending transmit-ready event while its status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | One-cycle event strobes, one per source |
| rsfull_i | input | 1 | Live receive-shift-full condition |
| busy_i | input | 1 | Live bus-busy condition |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 status (write-one-to-clear) |
| wr_data_i | input | 7 | Write data, one bit per source |
| vec_rd_i | input | 1 | Vector read strobe |
| status_o | output | 16 | Status word |
| vec_o | output | 3 | Encoded vector of the highest-priority enabled pending event |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the relations between the outputs. The interrupt must agree with a nonzero vector. A reported code must point at a set, enabled bit with no enabled bit below it. A status bit may only rise after its strobe. A write-one clear or a vector read must drop the targeted bit unless an event hits it in the same cycle. The live bits must track their inputs. Only the bench scenarios can show the order in which a full set of events drains under repeated reads. The same holds for the exhaustive agreement of the vector with every mask and pending combination, and for the transmit-ready mask-off sequence.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  // Register select of the write port
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  // Vector codes; the numeric order is the priority order
  typedef enum logic [2:0] {
    VEC_NONE = 3'd0,
    VEC_ARB  = 3'd1,
    VEC_NAK  = 3'd2,
    VEC_ACC  = 3'd3,
    VEC_RXR  = 3'd4,
    VEC_TXR  = 3'd5,
    VEC_STOP = 3'd6,
    VEC_SLV  = 3'd7
  } vec_code_e;

  // Next value of a sticky flag: a set in the same cycle beats a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Code reported for source index idx
  function automatic int unsigned code_of(input int unsigned idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/i2c_irq_mask.sv
module i2c_irq_mask #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] mask_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
    end else if (load_i) begin
      mask_o <= data_i;
    end
  end

endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  import i2c_irq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_o[i] <= 1'b0;
      end else begin
        flag_o[i] <= sticky_next(flag_o[i], set_i[i], clr_i[i]);
      end
    end
  end

endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
  parameter int N  = 7,
  parameter int CW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  grant_o,
  output logic [CW-1:0] code_o,
  output logic          any_o
);

  import i2c_irq_pkg::*;

  // seen[i] is high when some source below i is pending
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = pend_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | pend_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) begin
        code_o = code_o | CW'(code_of(i));
      end
    end
  end

endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec #(
  parameter int NUM_SRC    = 7,
  parameter int STAT_W     = 16,
  parameter int RSFULL_POS = 11,
  parameter int BUSY_POS   = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            evt_i,
  input  logic                          rsfull_i,
  input  logic                          busy_i,
  input  logic                          wr_en_i,
  input  logic                          wr_sel_i,
  input  logic [NUM_SRC-1:0]            wr_data_i,
  input  logic                          vec_rd_i,
  output logic [STAT_W-1:0]             status_o,
  output logic [$clog2(NUM_SRC+1)-1:0]  vec_o,
  output logic                          irq_o
);

  import i2c_irq_pkg::*;

  localparam int CODE_W = $clog2(NUM_SRC + 1);

  // Named internal events, visible to the bound checker
  reg_sel_e           sel;
  logic               mask_load;
  logic               stat_wr;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] w1c_clr;
  logic [NUM_SRC-1:0] rd_clr;
  logic [NUM_SRC-1:0] clr_all;
  logic               any_pend;
  logic               live_rsfull_q;
  logic               live_busy_q;

  assign sel       = reg_sel_e'(wr_sel_i);
  assign mask_load = wr_en_i && (sel == SEL_MASK);
  assign stat_wr   = wr_en_i && (sel == SEL_STAT);

  i2c_irq_mask #(.N(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (mask_load),
    .data_i (wr_data_i),
    .mask_o (mask_q)
  );

  assign pend    = flag_q & mask_q;
  assign w1c_clr = {NUM_SRC{stat_wr}} & wr_data_i;
  assign rd_clr  = {NUM_SRC{vec_rd_i}} & grant;
  assign clr_all = w1c_clr | rd_clr;

  i2c_irq_flags #(.N(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_i),
    .clr_i  (clr_all),
    .flag_o (flag_q)
  );

  i2c_irq_prio #(.N(NUM_SRC), .CW(CODE_W)) u_prio (
    .pend_i  (pend),
    .grant_o (grant),
    .code_o  (vec_o),
    .any_o   (any_pend)
  );

  // Live conditions, sampled once and never cleared by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_rsfull_q <= 1'b0;
      live_busy_q   <= 1'b0;
    end else begin
      live_rsfull_q <= rsfull_i;
      live_busy_q   <= busy_i;
    end
  end

  always_comb begin
    status_o                  = '0;
    status_o[NUM_SRC-1:0]     = flag_q;
    status_o[RSFULL_POS]      = live_rsfull_q;
    status_o[BUSY_POS]        = live_busy_q;
  end

  assign irq_o = any_pend;

endmodule

// File: rtl/i2c_irq_vec_chk.sv
module i2c_irq_vec_chk #(
  parameter int N   = 7,
  parameter int DW  = 16,
  parameter int CW  = 3,
  parameter int RSF = 11,
  parameter int BSY = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt_i,
  input logic          rsfull_i,
  input logic          busy_i,
  input logic          wr_en_i,
  input logic          wr_sel_i,
  input logic [N-1:0]  wr_data_i,
  input logic          vec_rd_i,
  input logic [DW-1:0] status_o,
  input logic [CW-1:0] vec_o,
  input logic          irq_o,
  input logic [N-1:0]  mask_q
);

  // R4
  irq_vec_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec_o != '0));

  // R3
  vec_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o != '0) |-> (status_o[vec_o - 1] && mask_q[vec_o - 1]));

  // R3
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o != '0) |-> ((status_o[N-1:0] & mask_q & ((N'(1) << (vec_o - 1)) - N'(1))) == '0));

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_o[N-1:0] & $past(evt_i)) == $past(evt_i)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o[N-1:0] & ~$past(status_o[N-1:0]) & ~$past(evt_i)) == '0));

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i) |=> ((status_o[N-1:0] & $past(wr_data_i) & ~$past(evt_i)) == '0));

  // R7
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_i && (vec_o != '0) && !evt_i[vec_o - 1]) |=> !status_o[$past(vec_o) - 1]);

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i) |=> (mask_q == $past(wr_data_i)));

  // R9
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o[BSY] == $past(busy_i)) && (status_o[RSF] == $past(rsfull_i))));

endmodule

bind i2c_irq_vec i2c_irq_vec_chk #(
  .N   (NUM_SRC),
  .DW  (STAT_W),
  .CW  ($clog2(NUM_SRC + 1)),
  .RSF (RSFULL_POS),
  .BSY (BUSY_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .rsfull_i  (rsfull_i),
  .busy_i    (busy_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .vec_rd_i  (vec_rd_i),
  .status_o  (status_o),
  .vec_o     (vec_o),
  .irq_o     (irq_o),
  .mask_q    (mask_q)
);

// File: tb/i2c_irq_vec_bench.sv
module i2c_irq_vec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        rsfull = 1'b0;
  logic        busy = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [6:0]  wr_data = '0;
  logic        vec_rd = 1'b0;
  logic [15:0] status;
  logic [2:0]  vec;
  logic        irq;

  int errors = 0;
  int total  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  i2c_irq_vec u_i2c_irq_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .rsfull_i  (rsfull),
    .busy_i    (busy),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .vec_rd_i  (vec_rd),
    .status_o  (status),
    .vec_o     (vec),
    .irq_o     (irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [6:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt = e;
    tick();
    evt = '0;
  endtask

  task automatic rd();
    vec_rd = 1'b1;
    tick();
    vec_rd = 1'b0;
  endtask

  // Lowest enabled pending source, reported as index plus one
  function automatic int want_vec(input int p, input int m);
    int both = p & m;
    for (int i = 0; i < 7; i++) begin
      if (((both >> i) & 1) == 1) return i + 1;
    end
    return 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 during reset
    chk(status == 16'h0 && vec == 3'd0 && irq == 1'b0, "R1 reset", {status, vec, irq}, 0);
    rst_n = 1'b1;
    tick();
    chk(status == 16'h0 && vec == 3'd0 && irq == 1'b0, "R1 after release", {status, vec, irq}, 0);
    // R1: mask starts all disabled; R2: all strobes latch
    pulse(7'h7F);
    chk(vec == 3'd0 && irq == 1'b0, "R1 mask clear", {vec, irq}, 0);
    chk(status == 16'h007F, "R2 all set", status, 16'h007F);
    wr(1'b1, 7'h7F);
    chk(status == 16'h0, "R6 clear all", status, 0);

    // Exhaustive sweep over mask and pending sets: R2 R3 R4 R5 R6
    for (int m = 0; m < 128; m++) begin
      wr(1'b0, 7'(m));
      for (int p = 0; p < 128; p++) begin
        pulse(7'(p));
        chk(status == 16'(p), "R2 sweep status", status, p);
        chk(int'(vec) == want_vec(p, m), "R3 R5 sweep vector", vec, want_vec(p, m));
        chk(irq == ((p & m) != 0), "R4 sweep irq", irq, (p & m) != 0);
        wr(1'b1, 7'h7F);
        chk(status == 16'h0, "R6 sweep clear", status, 0);
      end
    end

    // R7: drain by repeated vector reads, lowest code first
    wr(1'b0, 7'h7F);
    pulse(7'h7F);
    for (int k = 0; k < 7; k++) begin
      chk(int'(vec) == k + 1, "R7 drain order", vec, k + 1);
      rd();
      chk(int'(status) == ((32'h7F << (k + 1)) & 32'h7F), "R7 drain clear", status,
          (32'h7F << (k + 1)) & 32'h7F);
    end
    chk(vec == 3'd0 && irq == 1'b0, "R7 drained", {vec, irq}, 0);
    // R7: read with vector 0 leaves a masked-out bit alone
    wr(1'b0, 7'h00);
    pulse(7'h08);
    rd();
    chk(status == 16'h0008, "R7 read at zero", status, 16'h0008);

    // R6: partial write-one clear; zeros leave bits
    pulse(7'h7F);
    wr(1'b1, 7'h05);
    chk(status == 16'h007A, "R6 partial", status, 16'h007A);
    wr(1'b1, 7'h00);
    chk(status == 16'h007A, "R6 zero write", status, 16'h007A);
    wr(1'b1, 7'h7F);

    // R8: event against vector-read clear and against write-one clear
    wr(1'b0, 7'h04);
    pulse(7'h04);
    chk(vec == 3'd3, "R3 access ready code", vec, 3);
    evt = 7'h04; vec_rd = 1'b1; tick(); evt = '0; vec_rd = 1'b0;
    chk(status == 16'h0004, "R8 read vs event", status, 16'h0004);
    evt = 7'h04; wr_sel = 1'b1; wr_data = 7'h04; wr_en = 1'b1; tick();
    evt = '0; wr_en = 1'b0; wr_data = '0;
    chk(status == 16'h0004, "R8 w1c vs event", status, 16'h0004);
    wr(1'b1, 7'h04);
    chk(status == 16'h0, "R6 w1c alone", status, 0);
    // R7: read clears only the reported bit while another bit arrives
    wr(1'b0, 7'h09);
    pulse(7'h01);
    evt = 7'h08; vec_rd = 1'b1; tick(); evt = '0; vec_rd = 1'b0;
    chk(status == 16'h0008 && vec == 3'd4, "R7 read with other event", {status, 5'(vec)}, 16'h0008 * 32 + 4);
    wr(1'b1, 7'h7F);

    // R9: live bits
    busy = 1'b1; tick();
    chk(status == 16'h1000, "R9 busy", status, 16'h1000);
    rsfull = 1'b1; tick();
    chk(status == 16'h1800, "R9 rsfull", status, 16'h1800);
    wr(1'b1, 7'h7F);
    rd();
    chk(status == 16'h1800 && irq == 1'b0 && vec == 3'd0, "R9 immune", {status, vec, irq}, 16'h1800 * 16);
    busy = 1'b0; rsfull = 1'b0; tick();
    chk(status == 16'h0, "R9 follow low", status, 0);

    // R10: transmit-ready mask off
    wr(1'b0, 7'h10);
    pulse(7'h10);
    chk(irq == 1'b1 && vec == 3'd5, "R10 txr raised", {vec, irq}, 11);
    wr(1'b0, 7'h00);
    chk(irq == 1'b0 && vec == 3'd0 && status == 16'h0010, "R10 masked", {status, vec, irq}, 16'h0010 * 16);
    pulse(7'h10);
    chk(irq == 1'b0, "R10 stays low", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule